// File: doc/BRIEF.md
# Tagged Virtual Address Region Checker

This block classifies a 64-bit virtual address before it is handed to the translation walker. Each access comes with its access type: instruction fetch or data, privileged or unprivileged, normal or non-fault. It also comes with a TLB miss indication, a layout mode and the control fields for the low and high address regions. From these the block decides which region the address belongs to and whether the top byte takes part in the region match. It raises the fault that applies, flags accesses that must skip tag checking, and produces the sanitized value for a program-counter write of the same address.

In the two-region layout, bit 55 selects the region. In the single-range layout every address belongs to the low region. The page walk, the TLB and the permission checks sit outside this block. Every result is registered and appears one clock after the input is marked valid.

Top module: `va_region_classifier`

## Requirements
- R1: In the two-region layout (`dual_range`=1), `out_region_hi` equals address bit 55. In the single-range layout it is always 0 (low region).
- R2: With size offset S (from `cfg_size_lo` or `cfg_size_hi`), a region spans 2^(64−S) bytes. An address with any bit in [63:64−S] different from the region fill (0 for low, 1 for high) gets `out_fault`=1, a level-0 translation fault. S=0 never faults for range.
- R3: When the selected region's top-byte-ignore bit (`cfg_tbi`, index 0 low, 1 high) applies, bits 63:56 are left out of the R2 match, and `out_top_ignored` is 1.
- R4: When the selected region's data-only bit (`cfg_tbid`) is 1, top-byte ignore does not apply to instruction fetches (`acc_instr`=1). Cache-maintenance and address-translation operations are presented as data accesses.
- R5: An unprivileged access to a region whose `cfg_unpriv_deny` bit is 1 gets `out_fault`=1. This outranks every other fault.
- R6: If no level-0 fault applies, a TLB miss in a region whose `cfg_walk_off` bit is 1 gets `out_fault`=2 (walk-disabled fault). Without a miss this code never appears.
- R7: If none of the above applies, an unprivileged non-fault access that misses in a region whose `cfg_nf_walk_off` bit is 1 gets `out_fault`=3 (quiet failure, no exception). Otherwise `out_fault`=0.
- R8: `out_unchecked` is 1 when `cfg_tag_bypass[1]`=1 and address bits 59:55 are all ones, or when `cfg_tag_bypass[0]`=1 and those bits are all zeros.
- R9: `out_pc_target` keeps bits 55:0 of the address. Bits 63:56 are cleared when `cfg_tbi[0]`=1 and either the layout is single-range or bit 55 is 0. They are set to ones when the layout is two-region, bit 55 is 1 and `cfg_tbi[1]`=1. Otherwise they are unchanged.
- R10: All outputs change only one clock after `in_valid`=1 and `out_valid` rises with them. Without `in_valid` the outputs hold and `out_valid` is 0. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Access present this cycle |
| in_addr | input | 64 | Virtual address |
| acc_instr | input | 1 | 1 = instruction fetch, 0 = data |
| acc_unpriv | input | 1 | 1 = unprivileged access |
| acc_nonfault | input | 1 | 1 = non-fault access type |
| tlb_miss | input | 1 | Access missed in the TLB |
| dual_range | input | 1 | 1 = two-region layout, 0 = single range |
| cfg_size_lo | input | 6 | Low region size offset |
| cfg_size_hi | input | 6 | High region size offset |
| cfg_tbi | input | 2 | Top-byte ignore per region |
| cfg_tbid | input | 2 | Top-byte ignore for data only, per region |
| cfg_walk_off | input | 2 | Walk disable on miss, per region |
| cfg_unpriv_deny | input | 2 | Deny unprivileged access, per region |
| cfg_nf_walk_off | input | 2 | Non-fault walk disable, per region |
| cfg_tag_bypass | input | 2 | Tag-check bypass, per region |
| out_valid | output | 1 | Result valid |
| out_region_hi | output | 1 | 1 = high region selected |
| out_top_ignored | output | 1 | Top byte left out of the match |
| out_fault | output | 2 | 0 none, 1 level-0, 2 walk disabled, 3 quiet failure |
| out_unchecked | output | 1 | Access skips tag checking |
| out_pc_target | output | 64 | Sanitized program-counter value |

## Verification
The fault arbiter is where functions meet in one cycle. An unprivileged denial, a range violation, a walk-disabled miss and a non-fault quiet failure can all be true for the same access. The top-byte ignore choice also decides whether the range check fires at all. Directed cases stack these conditions on a single access, and random runs draw every per-region control bit and the miss flag independently so that overlaps are frequent. Each result is judged against a bench model that walks the address bit by bit and applies the priority order.

// File: rtl/va_cls_pkg.sv
package va_cls_pkg;
  parameter int VA_W     = 64;
  parameter int SZ_W     = 6;
  parameter int TAG_LSB  = 56;  // top byte starts here
  parameter int SEL_BIT  = 55;  // region select / fill bit
  parameter int TCHK_LSB = 55;  // tag-check bypass field
  parameter int TCHK_MSB = 59;
  parameter int NREG     = 2;   // index 0 low, 1 high

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_LEVEL0   = 2'd1,
    FLT_WALK_OFF = 2'd2,
    FLT_NF_QUIET = 2'd3
  } flt_e;

  // Bits that must equal the region fill for a region of size offset sz.
  function automatic logic [VA_W-1:0] span_mask(input logic [SZ_W-1:0] sz,
                                                input logic drop_top);
    logic [VA_W-1:0] m;
    if (sz == '0) m = '0;
    else          m = {VA_W{1'b1}} << (VA_W - int'(sz));
    if (drop_top) m[VA_W-1:TAG_LSB] = '0;
    return m;
  endfunction

  function automatic logic outside_span(input logic [VA_W-1:0] a,
                                        input logic [SZ_W-1:0] sz,
                                        input logic drop_top,
                                        input logic fill);
    return |((a ^ {VA_W{fill}}) & span_mask(sz, drop_top));
  endfunction

  function automatic logic [VA_W-1:0] pc_fix(input logic [VA_W-1:0] a,
                                             input logic dual,
                                             input logic t_lo,
                                             input logic t_hi);
    logic [VA_W-1:0] r;
    r = a;
    if (!dual || !a[SEL_BIT]) begin
      if (t_lo) r[VA_W-1:TAG_LSB] = '0;
    end else if (t_hi) begin
      r[VA_W-1:TAG_LSB] = '1;
    end
    return r;
  endfunction

  function automatic logic bypass_hit(input logic [VA_W-1:0] a,
                                      input logic b_lo,
                                      input logic b_hi);
    logic [TCHK_MSB-TCHK_LSB:0] f;
    f = a[TCHK_MSB:TCHK_LSB];
    return (b_hi && (&f)) || (b_lo && !(|f));
  endfunction
endpackage

// File: rtl/va_region_decode.sv
module va_region_decode
  import va_cls_pkg::*;
(
  input  logic [VA_W-1:0]      addr,
  input  logic                 is_instr,
  input  logic                 dual,
  input  logic [NREG*SZ_W-1:0] sz_flat,
  input  logic [NREG-1:0]      tbi,
  input  logic [NREG-1:0]      tbid,
  output logic                 sel_hi,
  output logic                 top_ign,
  output logic                 out_of_span
);
  logic [NREG-1:0] ign_r;
  logic [SZ_W-1:0] sz_sel;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // data-only qualifier suppresses ignore for instruction fetches
    assign ign_r[g] = tbi[g] & ~(tbid[g] & is_instr);
  end

  assign sel_hi  = dual & addr[SEL_BIT];
  assign top_ign = ign_r[sel_hi];

  always_comb begin
    sz_sel      = sz_flat[int'(sel_hi)*SZ_W +: SZ_W];
    out_of_span = outside_span(addr, sz_sel, top_ign, sel_hi);
  end
endmodule

// File: rtl/va_fault_arbiter.sv
module va_fault_arbiter
  import va_cls_pkg::*;
(
  input  logic unpriv,
  input  logic nonfault,
  input  logic miss,
  input  logic deny_sel,
  input  logic oor,
  input  logic walk_off_sel,
  input  logic nf_off_sel,
  output logic ev_deny,
  output flt_e fault
);
  logic ev_walk, ev_quiet;

  assign ev_deny  = unpriv & deny_sel;
  assign ev_walk  = miss & walk_off_sel;
  assign ev_quiet = miss & unpriv & nonfault & nf_off_sel;

  always_comb begin
    if (ev_deny)       fault = FLT_LEVEL0;
    else if (oor)      fault = FLT_LEVEL0;
    else if (ev_walk)  fault = FLT_WALK_OFF;
    else if (ev_quiet) fault = FLT_NF_QUIET;
    else               fault = FLT_NONE;
  end
endmodule

// File: rtl/va_tag_unit.sv
module va_tag_unit
  import va_cls_pkg::*;
(
  input  logic [VA_W-1:0] addr,
  input  logic            dual,
  input  logic [NREG-1:0] tbi,
  input  logic [NREG-1:0] bypass,
  output logic [VA_W-1:0] pc_target,
  output logic            unchecked
);
  assign pc_target = pc_fix(addr, dual, tbi[0], tbi[1]);
  assign unchecked = bypass_hit(addr, bypass[0], bypass[1]);
endmodule

// File: rtl/va_region_classifier.sv
module va_region_classifier
  import va_cls_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_addr,
  input  logic        acc_instr,
  input  logic        acc_unpriv,
  input  logic        acc_nonfault,
  input  logic        tlb_miss,
  input  logic        dual_range,
  input  logic [5:0]  cfg_size_lo,
  input  logic [5:0]  cfg_size_hi,
  input  logic [1:0]  cfg_tbi,
  input  logic [1:0]  cfg_tbid,
  input  logic [1:0]  cfg_walk_off,
  input  logic [1:0]  cfg_unpriv_deny,
  input  logic [1:0]  cfg_nf_walk_off,
  input  logic [1:0]  cfg_tag_bypass,
  output logic        out_valid,
  output logic        out_region_hi,
  output logic        out_top_ignored,
  output logic [1:0]  out_fault,
  output logic        out_unchecked,
  output logic [63:0] out_pc_target
);
  logic            w_sel_hi, w_top_ign, w_oor, w_ev_deny, w_unchk;
  flt_e            w_fault;
  logic [VA_W-1:0] w_pc;

  logic            q_valid, q_hi, q_ign, q_unchk;
  flt_e            q_fault;
  logic [VA_W-1:0] q_pc;

  va_region_decode u_dec (
    .addr        (in_addr),
    .is_instr    (acc_instr),
    .dual        (dual_range),
    .sz_flat     ({cfg_size_hi, cfg_size_lo}),
    .tbi         (cfg_tbi),
    .tbid        (cfg_tbid),
    .sel_hi      (w_sel_hi),
    .top_ign     (w_top_ign),
    .out_of_span (w_oor)
  );

  va_fault_arbiter u_arb (
    .unpriv       (acc_unpriv),
    .nonfault     (acc_nonfault),
    .miss         (tlb_miss),
    .deny_sel     (cfg_unpriv_deny[w_sel_hi]),
    .oor          (w_oor),
    .walk_off_sel (cfg_walk_off[w_sel_hi]),
    .nf_off_sel   (cfg_nf_walk_off[w_sel_hi]),
    .ev_deny      (w_ev_deny),
    .fault        (w_fault)
  );

  va_tag_unit u_tag (
    .addr      (in_addr),
    .dual      (dual_range),
    .tbi       (cfg_tbi),
    .bypass    (cfg_tag_bypass),
    .pc_target (w_pc),
    .unchecked (w_unchk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_hi    <= 1'b0;
      q_ign   <= 1'b0;
      q_unchk <= 1'b0;
      q_fault <= FLT_NONE;
      q_pc    <= '0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_hi    <= w_sel_hi;
        q_ign   <= w_top_ign;
        q_unchk <= w_unchk;
        q_fault <= w_fault;
        q_pc    <= w_pc;
      end
    end
  end

  assign out_valid       = q_valid;
  assign out_region_hi   = q_hi;
  assign out_top_ignored = q_ign;
  assign out_unchecked   = q_unchk;
  assign out_fault       = q_fault;
  assign out_pc_target   = q_pc;
endmodule

// File: rtl/va_cls_chk.sv
module va_cls_chk
  import va_cls_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_addr,
  input logic        acc_instr,
  input logic        acc_nonfault,
  input logic        tlb_miss,
  input logic        dual_range,
  input logic [1:0]  cfg_tbid,
  input logic [1:0]  cfg_tag_bypass,
  input logic        sel_hi,
  input logic        ev_deny,
  input logic        out_valid,
  input logic        out_region_hi,
  input logic        out_top_ignored,
  input logic [1:0]  out_fault,
  input logic        out_unchecked,
  input logic [63:0] out_pc_target
);
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_pc_target) && $stable(out_fault)); // R10
  AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dual_range |=> !out_region_hi); // R1
  AST_DUAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dual_range |=> out_region_hi == $past(in_addr[55])); // R1
  AST_TBID_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && acc_instr && cfg_tbid[sel_hi] |=> !out_top_ignored); // R4
  AST_DENY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ev_deny |=> out_fault == FLT_LEVEL0); // R5
  AST_WALK_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !tlb_miss |=> out_fault == FLT_NONE || out_fault == FLT_LEVEL0); // R6
  AST_QUIET_NEEDS_NF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !acc_nonfault |=> out_fault != FLT_NF_QUIET); // R7
  AST_UNCHK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cfg_tag_bypass == 2'b00 |=> !out_unchecked); // R8
  AST_PC_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_pc_target[55:0] == $past(in_addr[55:0])); // R9
endmodule

bind va_region_classifier va_cls_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_addr         (in_addr),
  .acc_instr       (acc_instr),
  .acc_nonfault    (acc_nonfault),
  .tlb_miss        (tlb_miss),
  .dual_range      (dual_range),
  .cfg_tbid        (cfg_tbid),
  .cfg_tag_bypass  (cfg_tag_bypass),
  .sel_hi          (w_sel_hi),
  .ev_deny         (w_ev_deny),
  .out_valid       (out_valid),
  .out_region_hi   (out_region_hi),
  .out_top_ignored (out_top_ignored),
  .out_fault       (out_fault),
  .out_unchecked   (out_unchecked),
  .out_pc_target   (out_pc_target)
);

// File: tb/sim_va_region_classifier.sv
module sim_va_region_classifier;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n, in_valid, acc_instr, acc_unpriv, acc_nonfault, tlb_miss, dual_range;
  logic [63:0] in_addr;
  logic [5:0]  cfg_size_lo, cfg_size_hi;
  logic [1:0]  cfg_tbi, cfg_tbid, cfg_walk_off, cfg_unpriv_deny, cfg_nf_walk_off, cfg_tag_bypass;
  logic        out_valid, out_region_hi, out_top_ignored, out_unchecked;
  logic [1:0]  out_fault;
  logic [63:0] out_pc_target;

  int total = 0;
  int bad = 0;
  logic [63:0] last_pc;
  logic [1:0]  last_fault;

  va_region_classifier u0 (.*);

  // ---------------- reference model ----------------
  function automatic int m_region();
    return (dual_range && in_addr[55]) ? 1 : 0;
  endfunction
  function automatic bit m_ign();
    int r = m_region();
    if (!cfg_tbi[r]) return 0;
    if (cfg_tbid[r] && acc_instr) return 0;
    return 1;
  endfunction
  function automatic bit m_outside();
    int r  = m_region();
    int sz = (r == 1) ? int'(cfg_size_hi) : int'(cfg_size_lo);
    bit fill = (r == 1);
    for (int i = 0; i < 64; i++) begin
      if (i >= 64 - sz && !(m_ign() && i >= 56) && in_addr[i] != fill) return 1;
    end
    return 0;
  endfunction
  function automatic logic [1:0] m_fault();
    int r = m_region();
    if (acc_unpriv && cfg_unpriv_deny[r]) return 2'd1;
    if (m_outside()) return 2'd1;
    if (tlb_miss && cfg_walk_off[r]) return 2'd2;
    if (tlb_miss && acc_unpriv && acc_nonfault && cfg_nf_walk_off[r]) return 2'd3;
    return 2'd0;
  endfunction
  function automatic bit m_unchk();
    bit all1 = 1, all0 = 1;
    for (int i = 55; i <= 59; i++) begin
      if (in_addr[i]) all0 = 0; else all1 = 0;
    end
    return (cfg_tag_bypass[1] && all1) || (cfg_tag_bypass[0] && all0);
  endfunction
  function automatic logic [63:0] m_pc();
    logic [63:0] p = in_addr;
    if (!dual_range) begin
      if (cfg_tbi[0]) p[63:56] = 8'h00;
    end else if (!in_addr[55]) begin
      if (cfg_tbi[0]) p[63:56] = 8'h00;
    end else if (cfg_tbi[1]) begin
      p[63:56] = 8'hFF;
    end
    return p;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one valid access (inputs already set), check one cycle later.
  task automatic run_one(input string tag);
    logic [1:0]  e_f  = m_fault();
    logic [63:0] e_pc = m_pc();
    bit e_r = (m_region() == 1);
    bit e_i = m_ign();
    bit e_u = m_unchk();
    in_valid = 1'b1;
    @(negedge clk);
    chk("R10", {tag, " valid"}, 64'(out_valid), 64'd1);
    chk("R1", {tag, " region"}, 64'(out_region_hi), 64'(e_r));
    chk("R3 R4", {tag, " top_ignored"}, 64'(out_top_ignored), 64'(e_i));
    chk("R2 R5 R6 R7", {tag, " fault"}, 64'(out_fault), 64'(e_f));
    chk("R8", {tag, " unchecked"}, 64'(out_unchecked), 64'(e_u));
    chk("R9", {tag, " pc"}, out_pc_target, e_pc);
    last_pc = e_pc;
    last_fault = e_f;
    in_valid = 1'b0;
  endtask

  task automatic clear_cfg();
    acc_instr = 0; acc_unpriv = 0; acc_nonfault = 0; tlb_miss = 0; dual_range = 1;
    cfg_size_lo = 6'd16; cfg_size_hi = 6'd16;
    cfg_tbi = 0; cfg_tbid = 0; cfg_walk_off = 0; cfg_unpriv_deny = 0;
    cfg_nf_walk_off = 0; cfg_tag_bypass = 0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_addr = 64'h0;
    clear_cfg();
    repeat (3) @(negedge clk);
    // reset state: R10
    chk("R10", "reset valid", 64'(out_valid), 64'd0);
    chk("R10", "reset fault", 64'(out_fault), 64'd0);
    chk("R10", "reset pc", out_pc_target, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1/R2: in-range low and high
    clear_cfg(); in_addr = 64'h0000_1234_5678_9ABC; run_one("low ok");
    in_addr = 64'hFFFF_8000_0000_1000; run_one("high ok");
    // R2: out of range
    in_addr = 64'h0001_0000_0000_0000; run_one("low oor");
    cfg_size_lo = 6'd0; run_one("size zero no range fault");
    // R10: idle holds outputs
    in_addr = 64'hDEAD_BEEF_0000_0000;
    @(negedge clk);
    chk("R10", "idle valid", 64'(out_valid), 64'd0);
    chk("R10", "idle pc hold", out_pc_target, last_pc);
    chk("R10", "idle fault hold", 64'(out_fault), 64'(last_fault));
    // R3/R9: top byte ignored on low region, PC cleared
    clear_cfg(); cfg_tbi = 2'b01; in_addr = 64'h5A00_1234_0000_0040; run_one("tbi low");
    // R4: instruction fetch with data-only qualifier
    cfg_tbid = 2'b01; acc_instr = 1; run_one("tbid fetch");
    acc_instr = 0; run_one("tbid data");
    // R9: high region sign fill
    clear_cfg(); cfg_tbi = 2'b10; in_addr = 64'h12FF_8000_0000_0040; run_one("tbi high pc");
    // R5: deny outranks walk-disable
    clear_cfg(); cfg_unpriv_deny = 2'b01; cfg_walk_off = 2'b01; tlb_miss = 1; acc_unpriv = 1;
    in_addr = 64'h0000_0000_0000_1000; run_one("deny over walk");
    // R6: walk disable with and without a miss
    acc_unpriv = 0; run_one("walk off miss");
    tlb_miss = 0; run_one("walk off hit");
    // R7: quiet failure, then suppressed by privilege and by walk-off
    clear_cfg(); cfg_nf_walk_off = 2'b10; acc_unpriv = 1; acc_nonfault = 1; tlb_miss = 1;
    in_addr = 64'hFFFF_FFFF_0000_2000; run_one("nf quiet");
    acc_unpriv = 0; run_one("nf privileged");
    acc_unpriv = 1; cfg_walk_off = 2'b10; run_one("nf under walk");
    // R8: tag bypass fields
    clear_cfg(); cfg_tag_bypass = 2'b10; in_addr = 64'hFFFF_8000_0000_0000; run_one("bypass hi");
    cfg_tag_bypass = 2'b01; in_addr = 64'h0000_0000_0000_0000; run_one("bypass lo");
    in_addr = 64'h0F80_0000_0000_0000; run_one("bypass lo miss");
    // R1/R9: single-range layout
    clear_cfg(); dual_range = 0; cfg_size_lo = 6'd8; in_addr = 64'h0080_0000_0000_0000;
    run_one("single bit55");
    cfg_size_lo = 6'd16; run_one("single oor");
    cfg_tbi = 2'b01; in_addr = 64'h7780_0000_0000_0000; cfg_size_lo = 6'd8; run_one("single pc clr");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      bit f = 1'($urandom);
      in_addr = {$urandom, $urandom};
      if (($urandom % 4) != 0) in_addr[63:40] = {24{f}};
      if (($urandom % 3) == 0) in_addr[40 + ($urandom % 24)] ^= 1'b1;
      if (($urandom % 4) == 0) in_addr[63:56] = 8'($urandom);
      dual_range   = (($urandom % 5) != 0);
      acc_instr    = 1'($urandom); acc_unpriv = 1'($urandom);
      acc_nonfault = 1'($urandom); tlb_miss   = 1'($urandom);
      cfg_size_lo  = (($urandom % 8) == 0) ? 6'd0 : 6'(8 + $urandom % 24);
      cfg_size_hi  = (($urandom % 8) == 0) ? 6'd0 : 6'(8 + $urandom % 24);
      cfg_tbi = 2'($urandom); cfg_tbid = 2'($urandom);
      cfg_walk_off = 2'($urandom & $urandom); cfg_unpriv_deny = 2'($urandom & $urandom);
      cfg_nf_walk_off = 2'($urandom); cfg_tag_bypass = 2'($urandom);
      run_one("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule